// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches an external counter value together with its count direction and a tick enable, and produces an active-high reference level. A 3-bit control field selects how the reference behaves. It can hold its level, act on an exact match between counter and compare value, be forced to a fixed level, or follow one of two pulse-width modes whose sense depends on the count direction.

The compare value is written through a simple write strobe. It either reaches the active comparator at once, or waits in a shadow copy until the next update event. Two outputs are derived from the reference: a primary output that follows it and a complementary output that is its inverse. Each has its own polarity bit. A protection input can lock the control field and the shadow-enable bit against writes.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the reference is low, the mode is 000 (frozen), shadowing is off and both compare copies are zero; out_p therefore equals pol_p and out_n equals the inverse of pol_n.
- R2: In mode 000 the reference keeps its level whatever the counter, compare value or tick enable do.
- R3: In mode 001 the reference goes high, and in mode 010 it goes low, on the clock edge that ends a cycle in which tick_en is high and cnt_val equals the active compare value; a match without tick_en has no effect.
- R4: In mode 011 the reference inverts on every qualified match (tick_en high and cnt_val equal to the active compare value) and holds otherwise.
- R5: Mode 100 drives the reference low and mode 101 drives it high on the next edge, regardless of tick_en and the counter.
- R6: Mode 110 level: counting up (cnt_dn=0) it is high when cnt_val < compare; counting down (cnt_dn=1) it is high when cnt_val <= compare.
- R7: Mode 111 level is the inverse of the mode 110 level for the same counter, direction and compare value.
- R8: In modes 110/111 the reference is loaded with the PWM level only on a tick where the level differs from the level at the previous tick, or on the first tick after the mode left 000. The level at the previous tick is computed with the formula picked by mode bit 0, whatever the mode was then. Otherwise the reference keeps its level.
- R9: With shadow enable set, a compare write lands in the shadow copy only, and the active value takes the shadow value on the edge that samples upd_evt high.
- R10: With shadow enable clear, in modes 000 to 101, or in 110/111 with spm=1, a compare write reaches the active value on the next edge.
- R11: In modes 110/111 with spm=0, compare writes are shadowed and wait for upd_evt, even when shadow enable is clear.
- R12: pol_p=1 makes out_p active low (out_p = reference XOR pol_p); out_n = (NOT reference) XOR pol_n.
- R13: While prot_lvl is 2'b11 and chan_sel is 2'b00, cfg_we leaves the mode and shadow-enable bit unchanged; any other protection or channel selection lets the write through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CW | Running counter value |
| cnt_dn | input | 1 | Count direction, 1 = down |
| tick_en | input | 1 | Counter tick enable; compares are evaluated when high |
| upd_evt | input | 1 | Update event strobe |
| spm | input | 1 | Single-pulse mode flag |
| cfg_we | input | 1 | Write strobe for mode and shadow enable |
| cfg_mode | input | 3 | New mode value |
| cfg_shen | input | 1 | New shadow-enable value |
| prot_lvl | input | 2 | Protection level |
| chan_sel | input | 2 | Channel function select, 00 = compare |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value write data |
| pol_p | input | 1 | Primary output polarity, 1 = active low |
| pol_n | input | 1 | Complementary output polarity, 1 = active low |
| oref | output | 1 | Active-high reference |
| out_p | output | 1 | Primary output |
| out_n | output | 1 | Complementary output |

## Verification
The bench goes after a compare write that comes while a shadow is pending: a design that skips the shadow would move the PWM edge before the update event, and one that never loads it would keep the old edge for good. It leaves a forced level for a PWM mode while the comparison is unchanged. A design that reloads on every tick would drop the forced level at once, where the correct one keeps it until the comparison flips. It checks the counter equal to the compare value in both directions, where the two PWM modes disagree on whether the edge is inclusive. It also tries mode writes under each protection and channel combination; a wrong lock decode either freezes a channel that should be writable or lets a locked mode change the outputs.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN = 3'b000,
    OC_SET    = 3'b001,
    OC_CLR    = 3'b010,
    OC_TOG    = 3'b011,
    OC_LOW    = 3'b100,
    OC_HIGH   = 3'b101,
    OC_PWM_A  = 3'b110,
    OC_PWM_B  = 3'b111
  } oc_mode_e;

  localparam logic [1:0] PROT_TOP  = 2'b11;
  localparam logic [1:0] SEL_CMP   = 2'b00;

  function automatic logic is_pwm(input oc_mode_e m);
    return (m == OC_PWM_A) || (m == OC_PWM_B);
  endfunction

  function automatic logic is_locked(input logic [1:0] prot, input logic [1:0] sel);
    return (prot == PROT_TOP) && (sel == SEL_CMP);
  endfunction

endpackage

// File: rtl/tmr_cmp_ctl.sv
module tmr_cmp_ctl
  import tmr_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_shen,
  input  logic [1:0] prot_lvl,
  input  logic [1:0] chan_sel,
  output oc_mode_e   mode_q,
  output logic       shen_q,
  output logic       lock
);

  assign lock = is_locked(prot_lvl, chan_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OC_FROZEN;
      shen_q <= 1'b0;
    end else if (cfg_we && !lock) begin
      mode_q <= oc_mode_e'(cfg_mode);
      shen_q <= cfg_shen;
    end
  end

endmodule

// File: rtl/tmr_cmp_val.sv
module tmr_cmp_val
  import tmr_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  oc_mode_e      mode,
  input  logic          shen,
  input  logic          spm,
  input  logic          upd_evt,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic          use_sh,
  output logic [CW-1:0] cmp_sh,
  output logic [CW-1:0] cmp_act
);

  // PWM without single-pulse mode always runs through the shadow
  assign use_sh = shen || (is_pwm(mode) && !spm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh  <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_we) cmp_sh <= cmp_wdata;
      if (use_sh) begin
        if (upd_evt) cmp_act <= cmp_sh;
      end else if (cmp_we) begin
        cmp_act <= cmp_wdata;
      end
    end
  end

endmodule

// File: rtl/tmr_cmp_ref.sv
module tmr_cmp_ref
  import tmr_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  oc_mode_e      mode,
  input  logic          tick_en,
  input  logic          cnt_dn,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_act,
  output logic          match,
  output logic          pwm_lvl,
  output logic          ref_q
);

  // inv=0: first PWM flavour, inv=1: its inverse
  function automatic logic pwm_level(input logic inv, input logic dn,
                                     input logic [CW-1:0] c, input logic [CW-1:0] v);
    logic act;
    act = dn ? (c <= v) : (c < v);
    return inv ? !act : act;
  endfunction

  logic arm_q, arm_d;
  logic lvlp_q;
  logic ref_d;
  logic pwm_take;

  assign match    = tick_en && (cnt_val == cmp_act);
  assign pwm_lvl  = pwm_level(mode[0], cnt_dn, cnt_val, cmp_act);
  assign pwm_take = tick_en && (arm_q || (pwm_lvl != lvlp_q));

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OC_FROZEN: ref_d = ref_q;
      OC_SET:    if (match) ref_d = 1'b1;
      OC_CLR:    if (match) ref_d = 1'b0;
      OC_TOG:    if (match) ref_d = !ref_q;
      OC_LOW:    ref_d = 1'b0;
      OC_HIGH:   ref_d = 1'b1;
      OC_PWM_A,
      OC_PWM_B:  if (pwm_take) ref_d = pwm_lvl;
      default:   ref_d = ref_q;
    endcase
  end

  always_comb begin
    if (mode == OC_FROZEN)  arm_d = 1'b1;
    else if (is_pwm(mode))  arm_d = tick_en ? 1'b0 : arm_q;
    else                    arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      arm_q  <= 1'b1;
      lvlp_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      arm_q <= arm_d;
      if (tick_en) lvlp_q <= pwm_lvl;
    end
  end

endmodule

// File: rtl/tmr_cmp_drv.sv
module tmr_cmp_drv #(
  parameter int NLANE = 2
) (
  input  logic             ref_lvl,
  input  logic [NLANE-1:0] pol,
  output logic [NLANE-1:0] pin
);

  // even lanes follow the reference, odd lanes its complement
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    if (g % 2 == 0) begin : g_true
      assign pin[g] = ref_lvl ^ pol[g];
    end else begin : g_comp
      assign pin[g] = !ref_lvl ^ pol[g];
    end
  end

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_dn,
  input  logic          tick_en,
  input  logic          upd_evt,
  input  logic          spm,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_shen,
  input  logic [1:0]    prot_lvl,
  input  logic [1:0]    chan_sel,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          pol_p,
  input  logic          pol_n,
  output logic          oref,
  output logic          out_p,
  output logic          out_n
);

  localparam int NLANE = 2;

  oc_mode_e        mode_q;
  logic [2:0]      mode_w;
  logic            shen_q;
  logic            lock;
  logic            use_sh;
  logic [CW-1:0]   cmp_sh;
  logic [CW-1:0]   cmp_act;
  logic            match;
  logic            pwm_lvl;
  logic            ref_q;
  logic [NLANE-1:0] pins;

  assign mode_w = mode_q;

  tmr_cmp_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cfg_shen (cfg_shen),
    .prot_lvl (prot_lvl),
    .chan_sel (chan_sel),
    .mode_q   (mode_q),
    .shen_q   (shen_q),
    .lock     (lock)
  );

  tmr_cmp_val #(.CW(CW)) u_val (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .shen      (shen_q),
    .spm       (spm),
    .upd_evt   (upd_evt),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .use_sh    (use_sh),
    .cmp_sh    (cmp_sh),
    .cmp_act   (cmp_act)
  );

  tmr_cmp_ref #(.CW(CW)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .tick_en (tick_en),
    .cnt_dn  (cnt_dn),
    .cnt_val (cnt_val),
    .cmp_act (cmp_act),
    .match   (match),
    .pwm_lvl (pwm_lvl),
    .ref_q   (ref_q)
  );

  tmr_cmp_drv #(.NLANE(NLANE)) u_drv (
    .ref_lvl (ref_q),
    .pol     ({pol_n, pol_p}),
    .pin     (pins)
  );

  assign oref  = ref_q;
  assign out_p = pins[0];
  assign out_n = pins[1];

endmodule

// File: rtl/tmr_cmp_chan_chk.sv
module tmr_cmp_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_w,
  input logic          oref,
  input logic          tick_en,
  input logic          match,
  input logic          cfg_we,
  input logic          lock,
  input logic          upd_evt,
  input logic          use_sh,
  input logic          cmp_we,
  input logic [CW-1:0] cmp_wdata,
  input logic [CW-1:0] cmp_sh,
  input logic [CW-1:0] cmp_act
);

  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b000) |=> $stable(oref));

  p_set_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b001 && match) |=> oref);

  p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && (mode_w == 3'b001 || mode_w == 3'b010 || mode_w == 3'b011)) |=> $stable(oref));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b011 && match) |=> (oref != $past(oref)));

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b100) |=> !oref);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == 3'b101) |=> oref);

  p_shadow_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && use_sh) |=> (cmp_act == $past(cmp_sh)));

  p_direct_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !use_sh) |=> (cmp_act == $past(cmp_wdata)));

  p_lock_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && lock) |=> $stable(mode_w));

endmodule

bind tmr_cmp_chan tmr_cmp_chan_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_w    (mode_w),
  .oref      (oref),
  .tick_en   (tick_en),
  .match     (match),
  .cfg_we    (cfg_we),
  .lock      (lock),
  .upd_evt   (upd_evt),
  .use_sh    (use_sh),
  .cmp_we    (cmp_we),
  .cmp_wdata (cmp_wdata),
  .cmp_sh    (cmp_sh),
  .cmp_act   (cmp_act)
);

// File: tb/tmr_cmp_chan_bench.sv
module tmr_cmp_chan_bench;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_dn = 1'b0;
  logic          tick_en = 1'b0;
  logic          upd_evt = 1'b0;
  logic          spm = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_mode = 3'b000;
  logic          cfg_shen = 1'b0;
  logic [1:0]    prot_lvl = 2'b00;
  logic [1:0]    chan_sel = 2'b00;
  logic          cmp_we = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic          pol_p = 1'b0;
  logic          pol_n = 1'b0;
  logic          oref, out_p, out_n;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  tmr_cmp_chan #(.CW(CW)) u_tmr_cmp_chan (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_dn(cnt_dn),
    .tick_en(tick_en), .upd_evt(upd_evt), .spm(spm), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_shen(cfg_shen), .prot_lvl(prot_lvl),
    .chan_sel(chan_sel), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .pol_p(pol_p), .pol_n(pol_n), .oref(oref), .out_p(out_p), .out_n(out_n)
  );

  // ---------------- reference model ----------------
  logic [2:0]    m_mode = 3'b000;
  logic          m_shen = 1'b0;
  logic [CW-1:0] m_sh = '0;
  logic [CW-1:0] m_act = '0;
  logic          m_ref = 1'b0;
  logic          m_arm = 1'b1;
  logic          m_lvlp = 1'b0;

  // R6/R7 level restated: high side of the compare, flipped for mode 111
  function automatic logic exp_level(input logic [2:0] md, input logic dn,
                                     input logic [CW-1:0] c, input logic [CW-1:0] v);
    logic hi;
    if (dn) hi = !(c > v);
    else    hi = (c < v);
    if (md[0]) hi = ~hi;
    return hi;
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'b000:         return "R2";
      3'b001, 3'b010: return "R3";
      3'b011:         return "R4";
      3'b100, 3'b101: return "R5";
      3'b110:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    logic          pwm_md, shadowed, lvl, hit, nref, narm;
    logic [2:0]    nmode;
    logic          nshen;
    logic [CW-1:0] nsh, nact;
    if (!rst_n) begin
      m_mode = 3'b000; m_shen = 1'b0; m_sh = '0; m_act = '0;
      m_ref = 1'b0; m_arm = 1'b1; m_lvlp = 1'b0;
    end else begin
      pwm_md   = (m_mode == 3'b110) || (m_mode == 3'b111);
      hit      = tick_en && (cnt_val == m_act);
      lvl      = exp_level(m_mode, cnt_dn, cnt_val, m_act);
      nref = m_ref;
      case (m_mode)
        3'b001: if (hit) nref = 1'b1;
        3'b010: if (hit) nref = 1'b0;
        3'b011: if (hit) nref = ~m_ref;
        3'b100: nref = 1'b0;
        3'b101: nref = 1'b1;
        3'b110, 3'b111: if (tick_en && (m_arm || lvl != m_lvlp)) nref = lvl;
        default: ;
      endcase
      if (m_mode == 3'b000) narm = 1'b1;
      else if (pwm_md)      narm = tick_en ? 1'b0 : m_arm;
      else                  narm = 1'b0;
      shadowed = m_shen || (pwm_md && !spm);
      nsh = cmp_we ? cmp_wdata : m_sh;
      nact = m_act;
      if (shadowed) begin
        if (upd_evt) nact = m_sh;
      end else if (cmp_we) nact = cmp_wdata;
      nmode = m_mode; nshen = m_shen;
      if (cfg_we && !(prot_lvl == 2'b11 && chan_sel == 2'b00)) begin
        nmode = cfg_mode; nshen = cfg_shen;
      end
      if (tick_en) m_lvlp = lvl;
      m_ref = nref; m_arm = narm; m_sh = nsh; m_act = nact;
      m_mode = nmode; m_shen = nshen;
    end
  end

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // sample midway between the input change and the next edge
  always @(negedge clk) begin
    string t;
    if (!done) begin
      t = (phase == "") ? tag_of(m_mode) : phase;
      check1(t, "oref", oref, m_ref);
      check1("R12", "out_p", out_p, m_ref ^ pol_p);
      check1("R12", "out_n", out_n, ~m_ref ^ pol_n);
      n_cyc++;
      if (n_cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=finish", n_cyc);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk); #5;
      cfg_we = 1'b0; cmp_we = 1'b0; upd_evt = 1'b0;
    end
  endtask

  task automatic set_mode(input logic [2:0] md, input logic sh);
    cfg_mode = md; cfg_shen = sh; cfg_we = 1'b1; cyc(1);
  endtask

  task automatic wr_cmp(input logic [CW-1:0] v);
    cmp_wdata = v; cmp_we = 1'b1; cyc(1);
  endtask

  task automatic tick_at(input logic [CW-1:0] c, input logic dn);
    cnt_val = c; cnt_dn = dn; tick_en = 1'b1; cyc(1); tick_en = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    phase = "R1";
    pol_n = 1'b1;
    cyc(3);
    pol_n = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    // immediate compare write and set/clear on match
    phase = "R10"; wr_cmp(8'd5); cyc(1);
    phase = "R3";  set_mode(3'b001, 1'b0);
    tick_at(8'd4, 1'b0); tick_at(8'd5, 1'b0); cyc(1);
    set_mode(3'b010, 1'b0);
    cnt_val = 8'd5; tick_en = 1'b0; cyc(2);          // match without tick: hold
    tick_at(8'd5, 1'b0); cyc(1);
    phase = "R4"; set_mode(3'b011, 1'b0);
    tick_at(8'd5, 1'b0); tick_at(8'd6, 1'b0); tick_at(8'd5, 1'b1); tick_at(8'd5, 1'b0);
    phase = "R5"; set_mode(3'b101, 1'b0); cyc(2); set_mode(3'b100, 1'b0); cyc(2);
    set_mode(3'b101, 1'b0); cyc(1);
    phase = "R2"; set_mode(3'b000, 1'b0);
    tick_at(8'd5, 1'b0); tick_at(8'd0, 1'b1); cyc(1);

    // PWM sweeps with single-pulse mode so writes stay immediate
    spm = 1'b1;
    phase = "R10"; wr_cmp(8'd4);
    phase = "R6"; set_mode(3'b110, 1'b0);
    for (int i = 0; i < 8; i++) tick_at(i[CW-1:0], 1'b0);
    for (int i = 7; i >= 0; i--) tick_at(i[CW-1:0], 1'b1);
    phase = "R7"; set_mode(3'b111, 1'b0);
    for (int i = 0; i < 8; i++) tick_at(i[CW-1:0], 1'b0);
    for (int i = 7; i >= 0; i--) tick_at(i[CW-1:0], 1'b1);

    // forced high then PWM with the comparison unchanged
    phase = "R8"; set_mode(3'b101, 1'b0); tick_at(8'd6, 1'b0);
    set_mode(3'b110, 1'b0);
    tick_at(8'd6, 1'b0); tick_at(8'd7, 1'b0); tick_at(8'd2, 1'b0); tick_at(8'd6, 1'b0);
    set_mode(3'b000, 1'b0); set_mode(3'b110, 1'b0); tick_at(8'd1, 1'b0); tick_at(8'd1, 1'b0);

    // shadowed compare
    phase = "R9"; set_mode(3'b110, 1'b1);
    wr_cmp(8'd10);
    tick_at(8'd6, 1'b0); tick_at(8'd8, 1'b0);
    upd_evt = 1'b1; cyc(1);
    tick_at(8'd8, 1'b0); tick_at(8'd11, 1'b0);

    // PWM without single-pulse: shadowed even with shadow disabled
    phase = "R11"; spm = 1'b0; set_mode(3'b110, 1'b0);
    wr_cmp(8'd3);
    tick_at(8'd5, 1'b0); tick_at(8'd9, 1'b0);
    upd_evt = 1'b1; cyc(1);
    tick_at(8'd5, 1'b0); tick_at(8'd2, 1'b0);

    // polarity
    phase = "R12";
    for (int i = 0; i < 4; i++) begin pol_p = i[0]; pol_n = i[1]; cyc(1); end
    set_mode(3'b100, 1'b0);
    for (int i = 0; i < 4; i++) begin pol_p = i[0]; pol_n = i[1]; cyc(1); end

    // protection
    phase = "R13"; set_mode(3'b101, 1'b0);
    prot_lvl = 2'b11; chan_sel = 2'b00; set_mode(3'b100, 1'b0); cyc(2);
    chan_sel = 2'b01; set_mode(3'b100, 1'b0); cyc(1);
    chan_sel = 2'b00; prot_lvl = 2'b10; set_mode(3'b101, 1'b0); cyc(1);
    prot_lvl = 2'b00;

    // constrained random
    phase = "";
    for (int k = 0; k < 4000; k++) begin
      cnt_val   = CW'($urandom_range(0, 15));
      cnt_dn    = $urandom_range(0, 1) == 1;
      tick_en   = $urandom_range(0, 3) != 0;
      upd_evt   = $urandom_range(0, 7) == 0;
      spm       = $urandom_range(0, 3) == 0;
      cmp_we    = $urandom_range(0, 7) == 0;
      cmp_wdata = CW'($urandom_range(0, 15));
      cfg_we    = $urandom_range(0, 15) == 0;
      cfg_mode  = 3'($urandom_range(0, 7));
      cfg_shen  = $urandom_range(0, 1) == 1;
      prot_lvl  = 2'($urandom_range(0, 3));
      chan_sel  = 2'($urandom_range(0, 3));
      pol_p     = $urandom_range(0, 1) == 1;
      pol_n     = $urandom_range(0, 1) == 1;
      @(posedge clk); #5;
    end
    cfg_we = 1'b0; cmp_we = 1'b0; upd_evt = 1'b0; tick_en = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule